// File: doc/BRIEF.md
# Iterative Multiply/Divide Coprocessor

This block is a small arithmetic engine that software drives through a handful of registers. There is a 32-bit accumulator A, seen as a low half and a high half, a 16-bit operand register B, a 16-bit remainder register R and a control register. Software loads the operands, then writes the control register with the enable bit set and the mode bit choosing the operation. The unit then works one bit per clock until the result is ready. It works in place: a multiply leaves the 32-bit product in A. A divide leaves the quotient in A and the remainder in R.

A multiply uses the low half of A as one factor and B as the other. Sixteen shift-add steps follow. A divide treats all of A as the dividend and B as the divisor. Thirty-two restoring shift-subtract steps follow. The enable bit reads back as a busy flag while the steps run. A one-cycle completion pulse marks the end. Software can cancel a running operation by writing the enable bit to 0. If that write lands on the final step, the result is kept and the pulse is still raised. A zero divisor does not stall the unit.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, A, B and R read 0, the control register reads 0 (busy clear, mode 0) and done_irq is low.
- R2: While idle, a write with bus_sel 0 (A low), 1 (A high) or 2 (B) loads bus_wdata into that register. It reads back in the cycle after the write. A read with bus_sel 3 returns R, and a read with bus_sel 4 returns the control register.
- R3: A control write (bus_sel 4) with bit 7 set while idle starts an operation, and bit 0 of that write selects the mode (1 = multiply, so 81H multiplies, and 0 = divide). Bit 7 of the control register then reads 1 for exactly 16 cycles in multiply mode or 32 cycles in divide mode. It then reads 0, and done_irq is high for exactly that one following cycle.
- R4: Starting any operation sets R to 0. Starting a multiply also sets the high half of A to 0, so any earlier high-half contents have no effect on the product.
- R5: On multiply completion, A holds the 32-bit product of the old low half of A and B, and R stays 0.
- R6: On divide completion with a nonzero divisor, A holds the 32-bit quotient of A divided by B, and R holds the remainder.
- R7: With B = 0000H in divide mode, the unit still completes after 32 cycles and raises done_irq. A then reads FFFFFFFFH and R reads the low half of the dividend.
- R8: A control write with bit 7 clear during an operation, before its final step, stops the operation. Busy reads 0 from the next cycle, and done_irq is not raised.
- R9: If that cancelling control write lands on the final step, the finished result is kept in A and R, and done_irq is still raised in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select: 0 A low, 1 A high, 2 B, 3 R, 4 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the edges of the busy window. A unit with a wrong step count shows busy one cycle too long or too short, and puts the pulse on the wrong cycle. It runs a multiply after loading the high half of A with ones and a divide after leaving R nonzero, so a unit that fails to clear those on start gives a wrong product or a wrong remainder. It also runs a zero divisor, an all-ones dividend over 1 and a divisor larger than the dividend, where a unit with a bad borrow test gives a wrong quotient or stalls. The two cancel cases are placed one cycle apart in effect: a cancel some cycles before the end must leave no pulse, and a cancel on the last step must keep the product and pulse. A unit that mixes up these two cases either loses a finished result or reports one that was cut short.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_A_LO = 3'd0;
  localparam logic [SEL_W-1:0] SEL_A_HI = 3'd1;
  localparam logic [SEL_W-1:0] SEL_B    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_REM  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_BIT = 0;
endpackage

// File: rtl/muldiv_rstsync.sv
module muldiv_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic ctrl_en,
  input  logic ctrl_mode,
  output logic busy,
  output logic mode_mul,
  output logic start,
  output logic step_en,
  output logic last,
  output logic kill,
  output logic done
);
  localparam int NSTEP_MAX = 2 * DW;
  localparam int CW        = $clog2(NSTEP_MAX);
  localparam logic [CW-1:0] MUL_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(NSTEP_MAX - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_n, mode_n, done_n;
  logic          abort_req, finish;
  logic          cnt_ce, mode_ce;

  assign start     = ctrl_we && ctrl_en && !busy;
  assign abort_req = ctrl_we && !ctrl_en && busy;
  assign last      = busy && (cnt_q == (mode_mul ? MUL_LAST : DIV_LAST));
  assign finish    = last;
  assign kill      = abort_req && !last;
  assign step_en   = busy && !kill;

  always_comb begin
    busy_n = busy;
    if (start)              busy_n = 1'b1;
    else if (finish || kill) busy_n = 1'b0;
    cnt_n  = start ? '0 : cnt_q + CW'(1);
    mode_n = ctrl_mode;
    done_n = finish;
  end

  assign cnt_ce  = start || step_en;
  assign mode_ce = ctrl_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt_q    <= '0;
      mode_mul <= 1'b0;
    end else begin
      busy <= busy_n;
      done <= done_n;
      if (cnt_ce)  cnt_q    <= cnt_n;
      if (mode_ce) mode_mul <= mode_n;
    end
  end
endmodule

// File: rtl/muldiv_mulstep.sv
module muldiv_mulstep #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] acc,
  input  logic [DW-1:0]   opb,
  output logic [2*DW-1:0] acc_n
);
  logic [DW:0] sum;

  always_comb begin
    sum   = {1'b0, acc[2*DW-1:DW]} + (acc[0] ? {1'b0, opb} : '0);
    acc_n = {sum, acc[DW-1:1]};
  end
endmodule

// File: rtl/muldiv_divstep.sv
module muldiv_divstep #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] acc,
  input  logic [DW-1:0]   rem,
  input  logic [DW-1:0]   opb,
  output logic [2*DW-1:0] acc_n,
  output logic [DW-1:0]   rem_n
);
  logic [DW:0]   shifted;
  logic [DW+1:0] diff;
  logic          ge;

  always_comb begin
    shifted = {rem, acc[2*DW-1]};
    diff    = {1'b0, shifted} - {2'b00, opb};
    ge      = !diff[DW+1];
    rem_n   = ge ? diff[DW-1:0] : shifted[DW-1:0];
    acc_n   = {acc[2*DW-2:0], ge};
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             done_irq
);
  localparam int AW = 2 * DW;

  logic          rst_q_n;
  logic [AW-1:0] acc_q, acc_n, mul_acc, div_acc;
  logic [DW-1:0] opb_q, opb_n, rem_q, rem_n, div_rem;
  logic          acc_ce, opb_ce, rem_ce;
  logic          wr_alo, wr_ahi, wr_b, ctrl_we;
  logic          busy, mode_mul, start, step_en, last, kill;

  muldiv_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign wr_alo  = bus_we && (bus_sel == SEL_A_LO);
  assign wr_ahi  = bus_we && (bus_sel == SEL_A_HI);
  assign wr_b    = bus_we && (bus_sel == SEL_B);
  assign ctrl_we = bus_we && (bus_sel == SEL_CTRL);

  muldiv_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .ctrl_we   (ctrl_we),
    .ctrl_en   (bus_wdata[CTRL_EN_BIT]),
    .ctrl_mode (bus_wdata[CTRL_MODE_BIT]),
    .busy      (busy),
    .mode_mul  (mode_mul),
    .start     (start),
    .step_en   (step_en),
    .last      (last),
    .kill      (kill),
    .done      (done_irq)
  );

  muldiv_mulstep #(.DW(DW)) u_mul (
    .acc   (acc_q),
    .opb   (opb_q),
    .acc_n (mul_acc)
  );

  muldiv_divstep #(.DW(DW)) u_div (
    .acc   (acc_q),
    .rem   (rem_q),
    .opb   (opb_q),
    .acc_n (div_acc),
    .rem_n (div_rem)
  );

  always_comb begin
    acc_n = acc_q;
    rem_n = rem_q;
    opb_n = opb_q;
    if (step_en) begin
      if (mode_mul) begin
        acc_n = mul_acc;
      end else begin
        acc_n = div_acc;
        rem_n = div_rem;
      end
    end
    if (start) begin
      rem_n = '0;
      if (bus_wdata[CTRL_MODE_BIT]) acc_n[AW-1:DW] = '0;
    end
    if (wr_alo) acc_n[DW-1:0]  = bus_wdata;
    if (wr_ahi) acc_n[AW-1:DW] = bus_wdata;
    if (wr_b)   opb_n          = bus_wdata;
  end

  assign acc_ce = step_en || start || wr_alo || wr_ahi;
  assign rem_ce = step_en || start;
  assign opb_ce = wr_b;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_q <= '0;
      opb_q <= '0;
      rem_q <= '0;
    end else begin
      if (acc_ce) acc_q <= acc_n;
      if (opb_ce) opb_q <= opb_n;
      if (rem_ce) rem_q <= rem_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      SEL_A_LO: bus_rdata = acc_q[DW-1:0];
      SEL_A_HI: bus_rdata = acc_q[AW-1:DW];
      SEL_B:    bus_rdata = opb_q;
      SEL_REM:  bus_rdata = rem_q;
      SEL_CTRL: begin
        bus_rdata[CTRL_EN_BIT]   = busy;
        bus_rdata[CTRL_MODE_BIT] = mode_mul;
      end
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          busy,
  input logic          start,
  input logic          last,
  input logic          kill,
  input logic          ctrl_we,
  input logic          ctrl_en,
  input logic          ctrl_mode,
  input logic          done_irq,
  input logic [DW-1:0] rem_q,
  input logic [DW-1:0] acc_hi
);
  localparam int RW = $clog2(2 * DW) + 2;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  run_len <= '0;
    else if (busy) run_len <= run_len + RW'(1);
    else           run_len <= '0;
  end

  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    run_len <= RW'(2 * DW));

  assert_irq_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_irq |-> (!busy && $past(busy)));

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_irq |=> !done_irq);

  assert_start_clears_rem_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> (rem_q == '0) && busy);

  assert_mul_clears_hi_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && ctrl_mode) |=> (acc_hi == '0));

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    kill |=> (!busy && !done_irq));

  assert_last_abort_kept_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (last && ctrl_we && !ctrl_en) |=> done_irq);
endmodule

bind muldiv_unit muldiv_unit_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .busy      (busy),
  .start     (start),
  .last      (last),
  .kill      (kill),
  .ctrl_we   (ctrl_we),
  .ctrl_en   (bus_wdata[7]),
  .ctrl_mode (bus_wdata[0]),
  .done_irq  (done_irq),
  .rem_q     (rem_q),
  .acc_hi    (acc_q[2*DW-1:DW])
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_sel;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        done_irq;

  muldiv_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done_irq  (done_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit cmp_on = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_a, m_res_a;
  logic [15:0] m_b, m_r, m_res_r;
  bit m_lo_k, m_hi_k, m_r_k;
  bit m_busy, m_mode, m_irq;
  int m_left;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog %s: actual hung expected done", cur_req);
      finish_run();
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_r = 0; m_lo_k = 1; m_hi_k = 1; m_r_k = 1;
      m_busy = 0; m_mode = 0; m_irq = 0; m_left = 0;
    end else begin
      m_irq = 0;
      if (bus_we && bus_sel == 3'd4) begin
        if (m_busy) begin
          if (!bus_wdata[7]) begin
            if (m_left == 1) begin
              m_busy = 0; m_irq = 1; m_a = m_res_a; m_r = m_res_r;
              m_lo_k = 1; m_hi_k = 1; m_r_k = 1;
            end else begin
              m_busy = 0; m_lo_k = 0; m_hi_k = 0;
              if (!m_mode) m_r_k = 0;
            end
          end else begin
            m_left--;
            if (m_left == 0) begin
              m_busy = 0; m_irq = 1; m_a = m_res_a; m_r = m_res_r;
              m_lo_k = 1; m_hi_k = 1; m_r_k = 1;
            end
          end
          m_mode = bus_wdata[0];
        end else begin
          m_mode = bus_wdata[0];
          if (bus_wdata[7]) begin
            m_busy = 1; m_r = 0; m_lo_k = 0; m_hi_k = 0;
            if (m_mode) begin
              m_left = 16; m_r_k = 1;
              m_res_a = {16'h0, m_a[15:0]} * {16'h0, m_b};
              m_res_r = 0;
            end else begin
              m_left = 32; m_r_k = 0;
              if (m_b == 0) begin
                m_res_a = 32'hFFFF_FFFF; m_res_r = m_a[15:0];
              end else begin
                m_res_a = m_a / {16'h0, m_b};
                m_res_r = 16'(m_a % {16'h0, m_b});
              end
            end
          end
        end
      end else begin
        if (m_busy) begin
          m_left--;
          if (m_left == 0) begin
            m_busy = 0; m_irq = 1; m_a = m_res_a; m_r = m_res_r;
            m_lo_k = 1; m_hi_k = 1; m_r_k = 1;
          end
        end
        if (bus_we && bus_sel == 3'd0) begin m_a[15:0]  = bus_wdata; m_lo_k = 1; end
        if (bus_we && bus_sel == 3'd1) begin m_a[31:16] = bus_wdata; m_hi_k = 1; end
        if (bus_we && bus_sel == 3'd2) m_b = bus_wdata;
      end
    end
    cmp_on = 1;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit known;
      logic [15:0] exp_d;
      known = 1;
      case (bus_sel)
        3'd0: begin exp_d = m_a[15:0];  known = m_lo_k; end
        3'd1: begin exp_d = m_a[31:16]; known = m_hi_k; end
        3'd2: exp_d = m_b;
        3'd3: begin exp_d = m_r; known = m_r_k; end
        3'd4: exp_d = {8'h00, m_busy, 6'b0, m_mode};
        default: exp_d = 16'h0;
      endcase
      n_cmp++;
      if (done_irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s done_irq: actual %b expected %b", cur_req, done_irq, m_irq);
      end
      if (known) begin
        n_cmp++;
        if (bus_rdata !== exp_d) begin
          n_bad++;
          $display("FAIL %s sel %0d: actual %h expected %h", cur_req, bus_sel, bus_rdata, exp_d);
        end
      end
    end
  end

  task automatic drive(input bit we, input logic [2:0] sel, input logic [15:0] d);
    @(posedge clk);
    #2;
    bus_we = we; bus_sel = sel; bus_wdata = d;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    drive(1, sel, d);
  endtask

  task automatic idle(input logic [2:0] sel);
    drive(0, sel, 16'h0);
  endtask

  task automatic read_all();
    for (int s = 0; s < 5; s++) idle(3'(s));
  endtask

  task automatic wait_done();
    idle(3'd4);
    while (m_busy) idle(3'd4);
    idle(3'd4);
  endtask

  task automatic run_mul(input logic [15:0] x, input logic [15:0] y);
    wr(3'd1, 16'hFFFF);
    wr(3'd0, x);
    wr(3'd2, y);
    cur_req = "R3";
    wr(3'd4, 16'h0081);
    wait_done();
    cur_req = "R5";
    read_all();
  endtask

  task automatic run_div(input logic [31:0] n, input logic [15:0] dv);
    wr(3'd1, n[31:16]);
    wr(3'd0, n[15:0]);
    wr(3'd2, dv);
    cur_req = "R3";
    wr(3'd4, 16'h0080);
    wait_done();
    cur_req = (dv == 0) ? "R7" : "R6";
    read_all();
  endtask

  initial begin
    rst_n = 1'b1; bus_we = 0; bus_sel = 3'd4; bus_wdata = 0;
    #1 rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) idle(3'd4);
    cur_req = "R1";
    read_all();

    cur_req = "R2";
    wr(3'd0, 16'h1234); idle(3'd0);
    wr(3'd1, 16'hABCD); idle(3'd1);
    wr(3'd2, 16'h5678); idle(3'd2);
    idle(3'd3); idle(3'd4);

    run_div(32'hDEAD_BEEF, 16'h1234);
    // R4: remainder left nonzero above, multiply start must clear it
    cur_req = "R4";
    run_mul(16'h0003, 16'h0005);
    run_mul(16'hFFFF, 16'hFFFF);
    run_mul(16'h0000, 16'hBEEF);
    run_mul(16'h1234, 16'h5678);
    run_div(32'd100, 16'd7);
    run_div(32'd5, 16'd9);
    run_div(32'hFFFF_FFFF, 16'h0001);
    run_div(32'h8000_0001, 16'hFFFF);
    run_div(32'h1234_5678, 16'h0000);

    // R8: cancel mid-way
    wr(3'd1, 16'h0012); wr(3'd0, 16'h3456); wr(3'd2, 16'h0077);
    cur_req = "R8";
    wr(3'd4, 16'h0080);
    repeat (10) idle(3'd4);
    wr(3'd4, 16'h0000);
    repeat (6) idle(3'd4);

    // R9: cancel on the last multiply step
    wr(3'd0, 16'h0321); wr(3'd2, 16'h0123);
    cur_req = "R9";
    wr(3'd4, 16'h0081);
    repeat (15) idle(3'd4);
    wr(3'd4, 16'h0001);
    idle(3'd4); idle(3'd4);
    read_all();

    repeat (3) idle(3'd4);
    finish_run();
  end
endmodule